// File: doc/BRIEF.md
# Addressed Register Frame Controller

This controller sits between a byte-level serial receiver and transmitter and a small register file. It watches the received byte stream for a fixed synchronisation value, then collects an addressed command: a device byte, a register address, up to eight data bytes for a write, and a trailing CRC. Only when the CRC matches and the device byte selects this node does it touch the register file. A write stores the buffered bytes at consecutive addresses and answers with a status byte and its CRC. A read-back answers with the addressed register contents followed by a CRC over them.

A frame with a bad CRC or a foreign address is consumed silently. Any stretch without bus activity longer than the programmed limit, while a frame is open, drops the partial frame. It also pulses a restart to the receiver, and the controller goes back to waiting for synchronisation. Every accepted frame produces a one-cycle watchdog-clear pulse.

Top module: `fc_frame_ctrl`

## Requirements
- R1: After reset, `tx_valid`, `reg_we`, `reg_re`, `wdt_clear` and `rx_restart` are all low.
- R2: Outside a frame, every received byte other than the sync value 0x55 is ignored, and a frame opens only on 0x55.
- R3: Device byte fields: bit 7 set means read, clear means write; bits 6:5 give the burst length as 1, 2, 4 or 8 bytes (code 0..3); bits 3:0 must equal `strap_addr`; bit 4 is ignored.
- R4: The frame CRC is CRC-8 with polynomial 0x07 and initial value 0x00, computed MSB-first over the device byte, the register byte and any data bytes (not over the sync byte). For an accepted write, `reg_we` is high for exactly burst-length cycles, storing data byte i at register address (base + i) mod 256, in arrival order.
- R5: An accepted write is answered with the status byte {4'h0, strap_addr} followed by the CRC-8 of that status byte.
- R6: An accepted read is answered with burst-length bytes read from (base + i) mod 256, then the CRC-8 over those reply bytes.
- R7: A frame whose received CRC differs from the computed one causes no register write, no reply byte and no watchdog-clear pulse.
- R8: A frame whose address nibble does not match is parsed to its CRC byte but causes no register write, no reply and no watchdog-clear pulse; a frame sent right after it is handled normally.
- R9: Each accepted frame (matching CRC and address) produces exactly one `wdt_clear` pulse one cycle long.
- R10: While a frame is open, if `bus_activity` stays low for more than `timeout_cycles` cycles, the frame is dropped, `rx_restart` pulses once, and the remaining bytes of that frame have no effect.
- R11: A reply byte offered on `tx_byte` with `tx_valid` high is held unchanged until `tx_ready` accepts it.
- R12: Each `bus_activity` pulse restarts the idle count, so a frame whose byte gaps are each shorter than the limit is accepted even if the frame as a whole lasts much longer than the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| bus_activity | input | 1 | Pulses on any bus edge seen by the receiver |
| timeout_cycles | input | TMO_W | Idle limit in clock cycles (configuration register) |
| strap_addr | input | 4 | This node's address |
| tx_valid | output | 1 | Reply byte available |
| tx_byte | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the byte when high with tx_valid |
| reg_addr | output | 8 | Register file address |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, combinational from reg_addr |
| wdt_clear | output | 1 | One-cycle pulse per accepted frame |
| rx_restart | output | 1 | One-cycle pulse when an open frame times out |

## Verification
The assertions check on every cycle that a read and a write strobe never coincide, that an offered reply byte stays stable while stalled, that a watchdog-clear pulse only follows an accepted frame, that a restart leaves the parser idle, and that stray bytes outside a frame never open one. The CRC arithmetic, the burst address wrap, the content and order of the replies, the silent discard of bad or foreign frames and the exact timeout boundary behaviour are only visible through the bench's frame scenarios. Those scenarios compare every reply byte and every register write against values the bench computes itself.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [7:0] CRC_POLY  = 8'h07;
  localparam int unsigned BURST_MAX = 8;
  localparam int unsigned IDX_W     = $clog2(BURST_MAX);

  typedef logic [BURST_MAX-1:0][7:0] burst_t;

  // One byte into a CRC-8, most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] c;
    c = acc ^ din;
    for (int b = 0; b < 8; b++) begin
      if (c[7]) c = {c[6:0], 1'b0} ^ CRC_POLY;
      else      c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  // Burst code 0..3 -> length minus one (0, 1, 3, 7).
  function automatic logic [IDX_W-1:0] len_m1_of(input logic [1:0] code);
    logic [3:0] n;
    n = 4'd1 << code;
    return IDX_W'(n - 4'd1);
  endfunction

  function automatic logic [7:0] status_of(input logic [3:0] node);
    return {4'h0, node};
  endfunction
endpackage

// File: rtl/fc_idle_timer.sv
module fc_idle_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame,
  input  logic             activity,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     idle_cnt <= '0;
    else if (!in_frame || activity) idle_cnt <= '0;
    else if (idle_cnt != '1)        idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired = in_frame && !activity && (idle_cnt >= limit);

  // R12
  act_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && activity) |=> !expired || (limit == '0));
endmodule

// File: rtl/fc_frame_rx.sv
module fc_frame_rx
  import fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             abort,
  input  logic [3:0]       strap,
  output logic             in_frame,
  output logic             frame_done,
  output logic             frame_good,
  output logic             fr_read,
  output logic [7:0]       fr_reg,
  output logic [IDX_W-1:0] fr_len_m1,
  output burst_t           fr_data
);
  typedef enum logic [2:0] {P_HUNT, P_DEV, P_REG, P_DATA, P_CRC} pst_t;

  pst_t             st;
  logic [7:0]       dev_q;
  logic [7:0]       crc_q;
  logic [IDX_W-1:0] cnt_q;

  assign in_frame   = (st != P_HUNT);
  assign fr_read    = dev_q[7];
  assign fr_len_m1  = len_m1_of(dev_q[6:5]);
  assign frame_done = (st == P_CRC) && rx_valid && !abort;
  assign frame_good = frame_done && (rx_byte == crc_q) && (dev_q[3:0] == strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= P_HUNT;
      dev_q   <= '0;
      fr_reg  <= '0;
      crc_q   <= '0;
      cnt_q   <= '0;
      fr_data <= '0;
    end else if (abort) begin
      st <= P_HUNT;
    end else if (rx_valid) begin
      unique case (st)
        P_HUNT: if (rx_byte == SYNC_BYTE) begin
          st    <= P_DEV;
          crc_q <= '0;
        end
        P_DEV: begin
          dev_q <= rx_byte;
          crc_q <= crc8_step(crc_q, rx_byte);
          st    <= P_REG;
        end
        P_REG: begin
          fr_reg <= rx_byte;
          crc_q  <= crc8_step(crc_q, rx_byte);
          cnt_q  <= '0;
          st     <= dev_q[7] ? P_CRC : P_DATA;
        end
        P_DATA: begin
          fr_data[cnt_q] <= rx_byte;
          crc_q          <= crc8_step(crc_q, rx_byte);
          cnt_q          <= cnt_q + 1'b1;
          if (cnt_q == fr_len_m1) st <= P_CRC;
        end
        P_CRC: st <= P_HUNT;
        default: st <= P_HUNT;
      endcase
    end
  end

  // R2
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && rx_valid && rx_byte != SYNC_BYTE) |=> !in_frame);
endmodule

// File: rtl/fc_reply_exec.sv
module fc_reply_exec
  import fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_in,
  input  logic             fr_read,
  input  logic [7:0]       fr_reg,
  input  logic [IDX_W-1:0] fr_len_m1,
  input  burst_t           fr_data,
  input  logic [3:0]       strap,
  output logic             busy,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             tx_ready,
  output logic [7:0]       reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  output logic             reg_re,
  input  logic [7:0]       reg_rdata,
  output logic             wdt_clear
);
  typedef enum logic [2:0] {E_IDLE, E_WR, E_STAT, E_RD, E_CRC} est_t;

  est_t             st;
  logic [7:0]       base_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       crc_q;
  logic             wdt_q;
  logic             take;

  assign busy      = (st != E_IDLE);
  assign wdt_clear = wdt_q;
  assign take      = tx_valid && tx_ready;
  assign reg_addr  = base_q + 8'(idx_q);
  assign reg_wdata = fr_data[idx_q];
  assign reg_we    = (st == E_WR);
  assign reg_re    = (st == E_RD);

  always_comb begin
    tx_valid = 1'b0;
    tx_byte  = 8'h00;
    unique case (st)
      E_STAT:  begin tx_valid = 1'b1; tx_byte = status_of(strap); end
      E_RD:    begin tx_valid = 1'b1; tx_byte = reg_rdata;        end
      E_CRC:   begin tx_valid = 1'b1; tx_byte = crc_q;            end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      base_q <= '0;
      last_q <= '0;
      idx_q  <= '0;
      crc_q  <= '0;
      wdt_q  <= 1'b0;
    end else begin
      wdt_q <= 1'b0;
      unique case (st)
        E_IDLE: if (accept_in) begin
          base_q <= fr_reg;
          last_q <= fr_len_m1;
          idx_q  <= '0;
          crc_q  <= '0;
          wdt_q  <= 1'b1;
          st     <= fr_read ? E_RD : E_WR;
        end
        E_WR: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == last_q) st <= E_STAT;
        end
        E_STAT: if (take) begin
          crc_q <= crc8_step(crc_q, tx_byte);
          st    <= E_CRC;
        end
        E_RD: if (take) begin
          crc_q <= crc8_step(crc_q, tx_byte);
          idx_q <= idx_q + 1'b1;
          if (idx_q == last_q) st <= E_CRC;
        end
        E_CRC: if (take) st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  // R4
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: rtl/fc_frame_ctrl.sv
module fc_frame_ctrl
  import fc_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             bus_activity,
  input  logic [TMO_W-1:0] timeout_cycles,
  input  logic [3:0]       strap_addr,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             tx_ready,
  output logic [7:0]       reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  output logic             reg_re,
  input  logic [7:0]       reg_rdata,
  output logic             wdt_clear,
  output logic             rx_restart
);
  logic             in_frame;
  logic             expired;
  logic             frame_done;
  logic             frame_good;
  logic             fr_read;
  logic [7:0]       fr_reg;
  logic [IDX_W-1:0] fr_len_m1;
  burst_t           fr_data;
  logic             busy;
  logic             accept;
  logic             restart_q;

  fc_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_frame (in_frame),
    .activity (bus_activity),
    .limit    (timeout_cycles),
    .expired  (expired)
  );

  fc_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .abort      (expired),
    .strap      (strap_addr),
    .in_frame   (in_frame),
    .frame_done (frame_done),
    .frame_good (frame_good),
    .fr_read    (fr_read),
    .fr_reg     (fr_reg),
    .fr_len_m1  (fr_len_m1),
    .fr_data    (fr_data)
  );

  // A frame finishing while a reply is still running is dropped.
  assign accept = frame_good && !busy;

  fc_reply_exec u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_in (accept),
    .fr_read   (fr_read),
    .fr_reg    (fr_reg),
    .fr_len_m1 (fr_len_m1),
    .fr_data   (fr_data),
    .strap     (strap_addr),
    .busy      (busy),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .tx_ready  (tx_ready),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .wdt_clear (wdt_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= expired;
  end
  assign rx_restart = restart_q;

  // R9
  wdt_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clear |-> $past(frame_good));

  // R10
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_restart |-> !in_frame);

  // R7
  bad_frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_good && !busy) |=> !wdt_clear && !busy);
endmodule

// File: tb/fc_frame_ctrl_tb.sv
module fc_frame_ctrl_tb;
  localparam logic [3:0] STRAP = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        bus_activity = 1'b0;
  logic [15:0] timeout_cycles = 16'd20;
  logic        tx_valid, reg_we, reg_re, wdt_clear, rx_restart;
  logic [7:0]  tx_byte, reg_addr, reg_wdata, reg_rdata;
  logic        tx_ready = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] dut_mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] tx_log [32];
  logic [7:0] wa_log [32];
  logic [7:0] wd_log [32];
  int tx_n, wr_n, wdt_n, rst_cnt;

  always #10 clk = ~clk;

  fc_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bus_activity(bus_activity), .timeout_cycles(timeout_cycles),
    .strap_addr(STRAP), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .wdt_clear(wdt_clear), .rx_restart(rx_restart)
  );

  assign reg_rdata = dut_mem[reg_addr];
  always @(posedge clk) if (reg_we) dut_mem[reg_addr] <= reg_wdata;

  bit rand_ready = 1'b0;
  always @(posedge clk) begin
    #1;
    tx_ready <= rand_ready ? (($urandom % 10) < 7) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) begin
      if (tx_n < 32) tx_log[tx_n] = tx_byte;
      tx_n++;
    end
    if (reg_we) begin
      if (wr_n < 32) begin wa_log[wr_n] = reg_addr; wd_log[wr_n] = reg_wdata; end
      wr_n++;
    end
    if (wdt_clear) wdt_n++;
    if (rx_restart) rst_cnt++;
  end

  function automatic logic [7:0] ref_crc(input logic [7:0] acc, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = acc;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    tx_n = 0; wr_n = 0; wdt_n = 0; rst_cnt = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; bus_activity = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_activity = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Sends a frame, waits for the reply, compares against bench expectations.
  task automatic run_frame(input logic [7:0] dev, input logic [7:0] rg,
                           input logic [63:0] data, input bit corrupt,
                           input int gap, input string tag);
    int n;
    logic [7:0] c;
    logic [7:0] exp_tx [16];
    int etx;
    bit ok;
    n = 1 << dev[6:5];
    clear_logs();
    c = 8'h00;
    send_byte(8'h55, gap);
    c = ref_crc(c, dev); send_byte(dev, gap);
    c = ref_crc(c, rg);  send_byte(rg, gap);
    if (!dev[7]) for (int i = 0; i < n; i++) begin
      c = ref_crc(c, data[8*i +: 8]);
      send_byte(data[8*i +: 8], gap);
    end
    send_byte(corrupt ? (c ^ 8'h5A) : c, 0);
    repeat (60) @(negedge clk);
    ok = !corrupt && (dev[3:0] == STRAP);
    etx = 0;
    c = 8'h00;
    if (ok && !dev[7]) begin
      for (int i = 0; i < n; i++) exp_mem[8'(rg + i)] = data[8*i +: 8];
      exp_tx[0] = {4'h0, STRAP}; c = ref_crc(c, exp_tx[0]); exp_tx[1] = c; etx = 2;
    end else if (ok) begin
      for (int i = 0; i < n; i++) begin
        exp_tx[i] = exp_mem[8'(rg + i)]; c = ref_crc(c, exp_tx[i]);
      end
      exp_tx[n] = c; etx = n + 1;
    end
    check({tag, " wdt pulses"}, wdt_n, ok ? 1 : 0);
    check({tag, " write count"}, wr_n, (ok && !dev[7]) ? n : 0);
    if (ok && !dev[7] && wr_n == n) for (int i = 0; i < n; i++) begin
      check({tag, " write addr"}, wa_log[i], 8'(rg + i));
      check({tag, " write data"}, wd_log[i], data[8*i +: 8]);
    end
    check({tag, " reply length"}, tx_n, etx);
    if (tx_n == etx) for (int i = 0; i < etx; i++)
      check({tag, " reply byte"}, tx_log[i], exp_tx[i]);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      dut_mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    clear_logs();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", tx_valid, 0);
    check("R1 reg_we", reg_we, 0);
    check("R1 reg_re", reg_re, 0);
    check("R1 wdt_clear", wdt_clear, 0);
    check("R1 rx_restart", rx_restart, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 stray bytes before sync, then a normal single write
    clear_logs();
    send_byte(8'hA0, 2); send_byte(8'h12, 2); send_byte(8'h34, 30);
    check("R2 stray no write", wr_n, 0);
    check("R2 stray no restart", rst_cnt, 0);
    run_frame({1'b0, 2'd0, 1'b0, STRAP}, 8'h10, 64'h3C, 0, 2, "R2 R4 single write");
    // R3 bit 4 ignored, R5 status reply
    run_frame({1'b0, 2'd1, 1'b1, STRAP}, 8'h20, 64'hBEEF, 0, 2, "R3 R5 burst2 write");
    // R4 burst of 8 wrapping past 0xFF
    run_frame({1'b0, 2'd3, 1'b0, STRAP}, 8'hFC, 64'h0102_0304_0506_0708, 0, 1, "R4 wrap write");
    // R6 reads, including the wrapped range
    run_frame({1'b1, 2'd3, 1'b0, STRAP}, 8'hFC, 64'h0, 0, 1, "R6 read8 wrap");
    run_frame({1'b1, 2'd0, 1'b0, STRAP}, 8'h10, 64'h0, 0, 2, "R6 read1");
    // R7 bad CRC
    run_frame({1'b0, 2'd2, 1'b0, STRAP}, 8'h40, 64'h1111_2222, 1, 2, "R7 bad crc write");
    run_frame({1'b1, 2'd2, 1'b0, STRAP}, 8'h40, 64'h0, 1, 2, "R7 bad crc read");
    // R8 foreign address, then a good frame right behind it
    run_frame({1'b0, 2'd1, 1'b0, STRAP ^ 4'h3}, 8'h50, 64'h6677, 0, 2, "R8 foreign write");
    run_frame({1'b1, 2'd1, 1'b0, STRAP}, 8'h50, 64'h0, 0, 2, "R8 follow read");

    // R10 timeout mid-frame: remaining bytes must have no effect
    clear_logs();
    send_byte(8'h55, 2); send_byte({1'b0, 2'd0, 1'b0, STRAP}, 2); send_byte(8'h60, 40);
    send_byte(8'h99, 2); send_byte(ref_crc(ref_crc(ref_crc(8'h00, {1'b0, 2'd0, 1'b0, STRAP}), 8'h60), 8'h99), 30);
    check("R10 restart pulses", rst_cnt, 1);
    check("R10 no write", wr_n, 0);
    check("R10 no reply", tx_n, 0);
    check("R10 no wdt", wdt_n, 0);
    // R12 gaps just under the limit
    run_frame({1'b0, 2'd2, 1'b0, STRAP}, 8'h70, 64'hA1B2_C3D4, 0, 17, "R12 slow write");
    check("R12 no restart", rst_cnt, 0);

    // R11 random ready back-pressure plus random frames
    rand_ready = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] dv;
      logic [63:0] dd;
      dv = 8'($urandom);
      if (($urandom % 5) != 0) dv[3:0] = STRAP;
      dd = {$urandom, $urandom};
      run_frame(dv, 8'($urandom), dd, ($urandom % 6) == 0, 1 + ($urandom % 4), "R11 R9 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule